// File: doc/BRIEF.md
# Round-Robin Series Memory Request Generator

This block drives directed traffic into a memory system that has several requester ports. It keeps exactly one single-byte request in flight at a time. It visits the ports in strict ascending order, each one at the same address. Once the last port has finished, it moves the address forward by a programmable step and starts again at port 0. A static mode input sets whether every request is a read or every request is a write. Writes always carry a zero data byte.

A request goes out on the active port through a valid/ready handshake. The generator then waits for a completion on that port's response channel. The completion must come back on the expected port and carry the expected address. Any other completion sets a sticky error flag and leaves the generator's progress unchanged. Each full pass over all ports adds one to a saturating pass counter. An enable input lets a pending request finish and holds back any new one.

Top module: `rr_series_gen`

## Requirements
- R1: Reset state: the active port is 0, the current address is 0, the pass counter is 0 and the error flag is clear. With `en` high, port 0 presents a request for address 0 in the first cycle after reset.
- R2: No more than one bit of `req_valid` is high at any time, and that bit belongs to the active port. While a request is pending, `req_valid` is all zero.
- R3: `req_data` is always 0. `req_write` equals `wr_mode` (1 = write, 0 = read).
- R4: A request that is not accepted stays on the same port with the same address until `req_ready` of that port is high in the same cycle. Only then does the generator become pending.
- R5: A completion is valid when all of these hold: a request is pending, the response bit is on the active port, and its address slice (bits `p*AW +: AW` of `rsp_addr`) equals the current address. A valid completion returns the generator to idle and selects the next port. That port presents its request in the very next cycle.
- R6: A valid completion on port NPORTS-1 wraps the active port to 0, adds `step` to the address and adds one to `cycles`.
- R7: A completion on a port that is not active, with a wrong address, or arriving while idle, sets `err`. `err` stays set until reset. Such a completion changes neither the port, the address, the counter nor the pending state.
- R8: With `en` low, no new request is presented. A pending request still completes normally.
- R9: The address wraps modulo 2^AW. `cycles` saturates at 2^CW-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Allows new requests to issue |
| wr_mode | input | 1 | 1 = all requests are writes, 0 = all are reads |
| step | input | AW | Address increment applied after each full pass |
| req_valid | output | NPORTS | Per-port request valid |
| req_ready | input | NPORTS | Per-port request ready |
| req_addr | output | AW | Request address, shared by all ports |
| req_write | output | 1 | Request is a write |
| req_data | output | 8 | Write data byte (always zero) |
| rsp_valid | input | NPORTS | Per-port completion valid |
| rsp_addr | input | NPORTS*AW | Per-port completion address, port p in bits p*AW +: AW |
| cycles | output | CW | Saturating count of completed passes |
| err | output | 1 | Sticky unexpected-completion flag |

## Verification
The bench keeps randomly stalled requests waiting under random ready. A design that dropped or moved the request would show a changed valid or address. It injects completions on the wrong port, with the wrong address, and while idle. A design that accepts any of these would advance the port early or would leave `err` clear. It drops enable while a request is pending, so a design that ignores enable would issue again. A long fast run pushes the address past 2^AW and the counter past its maximum, and a wrapping counter would read back a small value.

// File: rtl/rr_gen_pkg.sv
package rr_gen_pkg;

    typedef enum logic {
        GEN_IDLE = 1'b0,
        GEN_PEND = 1'b1
    } gen_state_e;

    typedef struct packed {
        logic good;
        logic bad;
    } rsp_verdict_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rr_rsp_check.sv
module rr_rsp_check
    import rr_gen_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int AW     = 16,
    localparam int IW    = idx_width(NPORTS)
) (
    input  logic                 pend,
    input  logic [IW-1:0]        idx,
    input  logic [AW-1:0]        cur_addr,
    input  logic [NPORTS-1:0]    rsp_valid,
    input  logic [NPORTS*AW-1:0] rsp_addr,
    output rsp_verdict_t         verdict
);
    logic [NPORTS-1:0] hit;
    logic [NPORTS-1:0] miss;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic match;
        assign match   = pend && (idx == IW'(p)) && (rsp_addr[p*AW +: AW] == cur_addr);
        assign hit[p]  = rsp_valid[p] && match;
        assign miss[p] = rsp_valid[p] && !match;
    end

    assign verdict.good = |hit;
    assign verdict.bad  = |miss;
endmodule

// File: rtl/rr_port_ptr.sv
module rr_port_ptr
    import rr_gen_pkg::*;
#(
    parameter int NPORTS = 4,
    localparam int IW    = idx_width(NPORTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [IW-1:0] idx,
    output logic          wrap
);
    localparam logic [IW-1:0] LAST = IW'(NPORTS - 1);

    assign wrap = adv && (idx == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (adv) begin
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end
endmodule

// File: rtl/rr_addr_cycle.sv
module rr_addr_cycle #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wrap,
    input  logic [AW-1:0] step,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] cycles
);
    localparam logic [CW-1:0] CMAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr   <= '0;
            cycles <= '0;
        end else if (wrap) begin
            addr <= addr + step;
            if (cycles != CMAX) begin
                cycles <= cycles + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rr_issue_ctrl.sv
module rr_issue_ctrl
    import rr_gen_pkg::*;
#(
    parameter int NPORTS = 4,
    localparam int IW    = idx_width(NPORTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [IW-1:0]     idx,
    input  logic [NPORTS-1:0] req_ready,
    input  rsp_verdict_t      verdict,
    output logic [NPORTS-1:0] req_valid,
    output logic              pend,
    output logic              adv,
    output logic              err
);
    gen_state_e state;
    logic       offer;
    logic       taken;

    assign offer = (state == GEN_IDLE) && en;
    assign taken = offer && req_ready[idx];
    assign pend  = (state == GEN_PEND);
    assign adv   = verdict.good;

    for (genvar p = 0; p < NPORTS; p++) begin : g_valid
        assign req_valid[p] = offer && (idx == IW'(p));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= GEN_IDLE;
            err   <= 1'b0;
        end else begin
            if (taken) begin
                state <= GEN_PEND;
            end else if (verdict.good) begin
                state <= GEN_IDLE;
            end
            if (verdict.bad) begin
                err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rr_series_gen.sv
module rr_series_gen
    import rr_gen_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int AW     = 16,
    parameter int CW     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 wr_mode,
    input  logic [AW-1:0]        step,
    output logic [NPORTS-1:0]    req_valid,
    input  logic [NPORTS-1:0]    req_ready,
    output logic [AW-1:0]        req_addr,
    output logic                 req_write,
    output logic [7:0]           req_data,
    input  logic [NPORTS-1:0]    rsp_valid,
    input  logic [NPORTS*AW-1:0] rsp_addr,
    output logic [CW-1:0]        cycles,
    output logic                 err
);
    localparam int IW = idx_width(NPORTS);

    logic [IW-1:0] idx;
    logic          wrap;
    logic          adv;
    logic          gen_pend;
    logic [AW-1:0] cur_addr;
    rsp_verdict_t  verdict;

    rr_rsp_check #(.NPORTS(NPORTS), .AW(AW)) u_chk_rsp (
        .pend      (gen_pend),
        .idx       (idx),
        .cur_addr  (cur_addr),
        .rsp_valid (rsp_valid),
        .rsp_addr  (rsp_addr),
        .verdict   (verdict)
    );

    rr_issue_ctrl #(.NPORTS(NPORTS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .idx       (idx),
        .req_ready (req_ready),
        .verdict   (verdict),
        .req_valid (req_valid),
        .pend      (gen_pend),
        .adv       (adv),
        .err       (err)
    );

    rr_port_ptr #(.NPORTS(NPORTS)) u_ptr (
        .clk  (clk),
        .rst  (rst),
        .adv  (adv),
        .idx  (idx),
        .wrap (wrap)
    );

    rr_addr_cycle #(.AW(AW), .CW(CW)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .wrap   (wrap),
        .step   (step),
        .addr   (cur_addr),
        .cycles (cycles)
    );

    assign req_addr  = cur_addr;
    assign req_write = wr_mode;
    assign req_data  = 8'h00;
endmodule

// File: rtl/rr_series_gen_chk.sv
module rr_series_gen_chk #(
    parameter int NPORTS = 4,
    parameter int AW     = 16,
    parameter int CW     = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              wr_mode,
    input logic [NPORTS-1:0] req_valid,
    input logic [NPORTS-1:0] req_ready,
    input logic [AW-1:0]     req_addr,
    input logic              req_write,
    input logic [7:0]        req_data,
    input logic [NPORTS-1:0] rsp_valid,
    input logic [CW-1:0]     cycles,
    input logic              err,
    input logic              gen_pend
);
    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_valid));

    a_r2_quiet_pending: assert property (@(posedge clk) disable iff (rst)
        gen_pend |-> (req_valid == '0));

    a_r3_fields: assert property (@(posedge clk) disable iff (rst)
        (|req_valid) |-> (req_data == 8'h00 && req_write == wr_mode));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst || !seen)
        ((|req_valid) && !(|(req_valid & req_ready)))
        |=> (!en || (req_valid == $past(req_valid) && req_addr == $past(req_addr))));

    a_r4_take: assert property (@(posedge clk) disable iff (rst || !seen)
        (|(req_valid & req_ready)) |=> gen_pend);

    a_r7_sticky: assert property (@(posedge clk) disable iff (rst || !seen)
        err |=> err);

    a_r7_idle_rsp: assert property (@(posedge clk) disable iff (rst || !seen)
        (!gen_pend && (|rsp_valid)) |=> err);

    a_r8_gate: assert property (@(posedge clk) disable iff (rst)
        !en |-> (req_valid == '0));

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst || !seen)
        seen |=> (cycles >= $past(cycles)));
endmodule

bind rr_series_gen rr_series_gen_chk #(.NPORTS(NPORTS), .AW(AW), .CW(CW)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .wr_mode   (wr_mode),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_data  (req_data),
    .rsp_valid (rsp_valid),
    .cycles    (cycles),
    .err       (err),
    .gen_pend  (gen_pend)
);

// File: tb/sim_rr_series_gen.sv
`timescale 1ns/1ps
module sim_rr_series_gen;
    localparam int N  = 4;
    localparam int AW = 16;
    localparam int CW = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            en = 1'b0;
    logic            wr_mode = 1'b0;
    logic [AW-1:0]   step = '0;
    logic [N-1:0]    req_valid;
    logic [N-1:0]    req_ready = '0;
    logic [AW-1:0]   req_addr;
    logic            req_write;
    logic [7:0]      req_data;
    logic [N-1:0]    rsp_valid = '0;
    logic [N*AW-1:0] rsp_addr = '0;
    logic [CW-1:0]   cycles;
    logic            err;

    always #2.5 clk = ~clk;

    rr_series_gen #(.NPORTS(N), .AW(AW), .CW(CW)) u0 (.*);

    int tests = 0;
    int fails = 0;
    int exp_idx;
    logic [AW-1:0] exp_addr;
    int exp_cnt;
    bit exp_err;

    task automatic chk(input string tag, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] onehot(input int i);
        return N'(1) << i;
    endfunction

    function automatic void model_good();
        exp_idx++;
        if (exp_idx == N) begin
            exp_idx  = 0;
            exp_addr = exp_addr + step;
            exp_cnt  = (exp_cnt < (1 << CW) - 1) ? exp_cnt + 1 : exp_cnt;
        end
    endfunction

    task automatic do_reset(input logic wm, input logic [AW-1:0] st);
        @(negedge clk);
        rst = 1'b1; en = 1'b1; wr_mode = wm; step = st;
        req_ready = '0; rsp_valid = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_idx = 0; exp_addr = '0; exp_cnt = 0; exp_err = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", req_valid, onehot(0));
        chk("R1 addr after reset", req_addr, 0);
        chk("R1 cycles after reset", cycles, 0);
        chk("R1 err after reset", err, 0);
    endtask

    task automatic respond(input int port, input logic [AW-1:0] a);
        rsp_valid = onehot(port);
        rsp_addr  = '0;
        rsp_addr[port*AW +: AW] = a;
        @(negedge clk);
        rsp_valid = '0;
    endtask

    // one request/completion; fast: ready at once, no delay
    task automatic one_txn(input bit fast, input int bad);
        bit acc = 0;
        while (!acc) begin
            chk("R2 R4 valid on active port", req_valid, onehot(exp_idx));
            chk("R4 addr held", req_addr, exp_addr);
            chk("R3 write and data", {req_write, req_data}, {wr_mode, 8'h00});
            acc = fast || ($urandom % 3 == 0);
            req_ready = acc ? onehot(exp_idx) : ($urandom % 2 ? ~onehot(exp_idx) : '0);
            @(negedge clk);
        end
        req_ready = '0;
        chk("R2 quiet while pending", req_valid, 0);
        if (!fast) repeat ($urandom % 3) @(negedge clk);
        if (bad == 1) begin
            respond((exp_idx + 1) % N, exp_addr);
            exp_err = 1'b1;
            chk("R7 wrong port sets err", err, 1);
            chk("R7 wrong port keeps pending", req_valid, 0);
        end else if (bad == 2) begin
            respond(exp_idx, exp_addr + 1'b1);
            exp_err = 1'b1;
            chk("R7 wrong addr sets err", err, 1);
            chk("R7 wrong addr keeps pending", req_valid, 0);
        end
        respond(exp_idx, exp_addr);
        model_good();
        if (en) begin
            chk("R5 next port next cycle", req_valid, onehot(exp_idx));
            chk("R6 R9 address", req_addr, exp_addr);
        end
        chk("R6 R9 cycles", cycles, exp_cnt);
        chk("R7 err", err, exp_err);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1357));

        // random reads, step 4, some bad completions
        do_reset(1'b0, 16'd4);
        for (int i = 0; i < 80; i++) begin
            int b = ($urandom % 8 == 0) ? 1 + ($urandom % 2) : 0;
            one_txn(1'b0, b);
        end

        // directed: writes, enable gating, idle completion
        do_reset(1'b1, 16'h0010);
        for (int i = 0; i < 6; i++) one_txn(1'b0, 0);
        chk("R6 pass count after 6", cycles, 1);
        // drop enable while pending
        req_ready = onehot(exp_idx);
        @(negedge clk);
        req_ready = '0;
        en = 1'b0;
        respond(exp_idx, exp_addr);
        model_good();
        chk("R8 pending finishes", err, 0);
        for (int i = 0; i < 4; i++) begin
            chk("R8 no issue with en low", req_valid, 0);
            @(negedge clk);
        end
        // completion while idle
        respond(exp_idx, exp_addr);
        chk("R7 idle completion sets err", err, 1);
        chk("R7 idle completion no count", cycles, exp_cnt);
        en = 1'b1;
        @(negedge clk);
        chk("R7 R8 same port after idle rsp", req_valid, onehot(exp_idx));
        chk("R7 same addr after idle rsp", req_addr, exp_addr);
        exp_err = 1'b1;
        for (int i = 0; i < 5; i++) one_txn(1'b0, 0);

        // saturation and address wrap
        do_reset(1'b0, 16'h1000);
        for (int i = 0; i < 262 * N; i++) one_txn(1'b1, 0);
        chk("R9 counter saturated", cycles, 255);
        chk("R9 addr wrapped", req_addr, AW'(262 * 16'h1000));

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule